// File: doc/BRIEF.md
# Main-Clock Loss Detector with Reset Request

This block watches a main oscillator clock, which it treats as a plain data input, and times its activity with a free-running reference clock. While detection is armed and the main clock stops toggling for longer than a set number of reference cycles, the block raises a sticky loss flag. If reset requests are allowed, it also asserts an internal reset request for a fixed number of reference cycles.

Software controls the block through one byte-wide register on a single-cycle write port, and the register contents are always visible on the read port. The two kinds of reset treat the register differently. An external reset clears everything. The reset that the block raises itself keeps the loss flag and the armed bit, so software can still see them after that reset ends. The same register also holds a bit that decides whether leaving stop mode raises a request to preload the timer and prescaler.

All logic runs on the reference clock. The reset is synchronous and active low.

Top module: `clkloss_ctrl`

## Requirements
- R1: While rst_ext_n is low at a rising reference edge, the register returns to 0x00 and int_rst_req and preload_req are 0. This also clears a set loss flag.
- R2: The register layout is: bit0 = stabilisation-skip, bit1 = detection armed, bit2 = reset-request enable, bit3 = loss flag. Bits 7:4 always read 0 and ignore writes. A write of bits 2:0 shows on reg_rdata after the capturing edge.
- R3: While bit1 is 0, a stopped main clock never sets the loss flag and never raises int_rst_req.
- R4: With bit1 set, the loss flag rises on the (SYNC_STAGES+1+TIMEOUT)th rising reference edge after the main clock's last level change. Level changes spaced TIMEOUT reference cycles apart never set it. A spacing of TIMEOUT+1 cycles does set it.
- R5: When loss is detected and bit2 is 1, int_rst_req goes high on the same edge as the flag and stays high for exactly PULSE_LEN cycles. When bit2 is 0, only the flag is set.
- R6: A loss that raises a reset request clears bit0 and bit2, and leaves bit1 and the flag (bit3) at 1. The register then reads 0x0A.
- R7: Writing 0 to bit1 clears the loss flag. Writing 1 to bit1 leaves the flag as it was. Bit3 of write data is ignored.
- R8: The loss flag stays set until R1 or R7 clears it. A single loss event produces only one request pulse, however long the main clock stays stopped.
- R9: Register writes made while int_rst_req is high are ignored.
- R10: preload_req pulses one cycle after a stop_exit pulse if bit0 is 0, and stays low if bit0 is 1. tmr_load_val reads 0x01 and pre_load_val reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_ext_n | input | 1 | External reset, synchronous, active low |
| main_clk | input | 1 | Watched main clock, sampled as data |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register contents |
| stop_exit | input | 1 | One-cycle pulse when stop mode ends |
| int_rst_req | output | 1 | Internal reset request pulse |
| preload_req | output | 1 | Timer/prescaler preload request |
| tmr_load_val | output | 8 | Timer preload value |
| pre_load_val | output | 8 | Prescaler preload value |

## Verification
The bench builds the block with its default values: two synchroniser stages, a 16-cycle timeout and an 8-cycle request pulse. With these values the whole detection latency of 19 edges, and both sides of the timeout boundary (spacing 16 against spacing 17), fit in short runs. The 8-cycle pulse is long enough to place a register write inside it and to confirm that only one pulse follows a long stop. Random toggle spacings up to the timeout, together with random register contents, check every combination of the enable and skip bits against the rules for a self-caused reset.

// File: rtl/clkloss_pkg.sv
// Package: shared register layout for the main-clock loss detector.
// Assumes a packed struct whose LSB is bit0 of the register.
package clkloss_pkg;
    localparam int REG_W = 8;
    localparam int CTL_W = 4;

    typedef struct packed {
        logic loss;      // bit3: sticky loss flag
        logic rst_en;    // bit2: reset request allowed
        logic armed;     // bit1: detection armed
        logic stab_skip; // bit0: skip preload on stop exit
    } ctl_t;
endpackage

// File: rtl/clkloss_edge_sync.sv
// Module: brings the watched clock into the reference domain and flags
// each level change. Assumes STAGES >= 2. One extra history flop follows
// the synchroniser, so a change shows on toggle_o STAGES-1 edges after capture.
module clkloss_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic toggle_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] shr;

    // first stage captures the asynchronous input
    always_ff @(posedge clk) begin
        if (!rst_n) shr[0] <= 1'b0;
        else        shr[0] <= din;
    end

    genvar gi;
    generate
        for (gi = 1; gi <= LAST; gi++) begin : g_stage
            // each later stage delays the previous one by a cycle
            always_ff @(posedge clk) begin
                if (!rst_n) shr[gi] <= 1'b0;
                else        shr[gi] <= shr[gi-1];
            end
        end
    endgenerate

    assign toggle_o = shr[LAST] ^ shr[LAST-1];
endmodule

// File: rtl/clkloss_timeout.sv
// Module: counts reference cycles without a main-clock toggle and fires a
// single-cycle loss strobe when TIMEOUT is reached. The count saturates, so
// it fires once per stop until a toggle arrives or detection is disarmed.
module clkloss_timeout #(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic toggle,
    output logic lost_o
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);
    localparam logic [CW-1:0] LAST  = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;

    // silence counter: restart on toggle or disarm, saturate at LIMIT
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (!armed || toggle) cnt <= '0;
        else if (cnt != LIMIT)     cnt <= cnt + 1'b1;
    end

    assign lost_o = armed && !toggle && (cnt == LAST);

    AST_CNT_CLEAR_ON_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> (cnt == '0));                                        // R4
    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);                                                   // R8
    AST_LOST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o |=> !lost_o);                                             // R8
endmodule

// File: rtl/clkloss_rst_pulse.sv
// Module: stretches a start strobe into a request that lasts exactly
// PULSE_LEN reference cycles. Assumes no new start while the request is high.
module clkloss_rst_pulse #(
    parameter int PULSE_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic req_o
);
    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] LOAD = PW'(PULSE_LEN);

    logic [PW-1:0] left;

    // remaining cycles of the request
    always_ff @(posedge clk) begin
        if (!rst_n)           left <= '0;
        else if (start)       left <= LOAD;
        else if (left != '0)  left <= left - 1'b1;
    end

    assign req_o = (left != '0);

    AST_REQ_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(start));                                  // R5
    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (left > 1) |=> req_o);                                           // R5
endmodule

// File: rtl/clkloss_regs.sv
// Module: control/status register and the reset and clear rules. A loss
// strobe has priority over a write in the same cycle. Writes are dropped
// while the block's own reset request is active.
module clkloss_regs
    import clkloss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [2:0] wdata,
    input  logic       lost,
    input  logic       busy,
    input  logic       stop_exit,
    output ctl_t       ctl_o,
    output logic       rst_start_o,
    output logic       preload_o
);
    ctl_t ctl;
    logic wr_ok;

    assign wr_ok       = wr && !busy;
    assign rst_start_o = lost && ctl.rst_en;

    // register update: loss first, then software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (lost) begin
            ctl.loss <= 1'b1;
            if (ctl.rst_en) begin
                ctl.rst_en    <= 1'b0;
                ctl.stab_skip <= 1'b0;
            end
        end else if (wr_ok) begin
            ctl.stab_skip <= wdata[0];
            ctl.armed     <= wdata[1];
            ctl.rst_en    <= wdata[2];
            if (!wdata[1]) ctl.loss <= 1'b0;
        end
    end

    // preload request one cycle after leaving stop mode
    always_ff @(posedge clk) begin
        if (!rst_n) preload_o <= 1'b0;
        else        preload_o <= stop_exit && !ctl.stab_skip;
    end

    assign ctl_o = ctl;

    AST_LOSS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.loss && !(wr_ok && !wdata[1]) |=> ctl.loss);                 // R8
    AST_ARMED_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> ctl.armed && ctl.loss);                                 // R6
    AST_SELF_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_start_o |=> !ctl.rst_en && !ctl.stab_skip);                  // R6
    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !lost |=> $stable(ctl));                                 // R9
    AST_PRELOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        preload_o |-> $past(!ctl.stab_skip && stop_exit));               // R10
endmodule

// File: rtl/clkloss_ctrl.sv
// Module: top of the main-clock loss detector. Everything is clocked by the
// free-running reference clock. main_clk is sampled as data. Assumes the
// reference clock runs while the main clock is stopped.
module clkloss_ctrl #(
    parameter int         SYNC_STAGES = 2,
    parameter int         TIMEOUT     = 16,
    parameter int         PULSE_LEN   = 8,
    parameter logic [7:0] TMR_LOAD    = 8'h01,
    parameter logic [7:0] PRE_LOAD    = 8'hFF
) (
    input  logic       clk_ref,
    input  logic       rst_ext_n,
    input  logic       main_clk,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       stop_exit,
    output logic       int_rst_req,
    output logic       preload_req,
    output logic [7:0] tmr_load_val,
    output logic [7:0] pre_load_val
);
    import clkloss_pkg::*;

    logic toggle;
    logic lost;
    logic rst_start;
    ctl_t ctl;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[7:3];

    clkloss_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_ref),
        .rst_n    (rst_ext_n),
        .din      (main_clk),
        .toggle_o (toggle)
    );

    clkloss_timeout #(.TIMEOUT(TIMEOUT)) u_tmo (
        .clk    (clk_ref),
        .rst_n  (rst_ext_n),
        .armed  (ctl.armed),
        .toggle (toggle),
        .lost_o (lost)
    );

    clkloss_regs u_regs (
        .clk         (clk_ref),
        .rst_n       (rst_ext_n),
        .wr          (reg_wr),
        .wdata       (reg_wdata[2:0]),
        .lost        (lost),
        .busy        (int_rst_req),
        .stop_exit   (stop_exit),
        .ctl_o       (ctl),
        .rst_start_o (rst_start),
        .preload_o   (preload_req)
    );

    clkloss_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk   (clk_ref),
        .rst_n (rst_ext_n),
        .start (rst_start),
        .req_o (int_rst_req)
    );

    assign reg_rdata    = {{(REG_W-CTL_W){1'b0}}, ctl};
    assign tmr_load_val = TMR_LOAD;
    assign pre_load_val = PRE_LOAD;

    AST_DISARMED_QUIET: assert property (@(posedge clk_ref) disable iff (!rst_ext_n)
        !ctl.armed && !int_rst_req |=> !int_rst_req);                    // R3
    AST_LOSS_NEEDS_ARMED: assert property (@(posedge clk_ref) disable iff (!rst_ext_n)
        $rose(reg_rdata[3]) |-> $past(ctl.armed));                       // R3
endmodule

// File: tb/clkloss_ctrl_tb_top.sv
module clkloss_ctrl_tb_top;
    localparam int SYNC = 2;
    localparam int T    = 16;
    localparam int PL   = 8;
    localparam int LAT  = SYNC + 1 + T;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mclk = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wd = 8'h00;
    logic [7:0] rd;
    logic       sexit = 1'b0;
    logic       req;
    logic       pre;
    logic [7:0] tval, pval;

    int checks = 0;
    int fails = 0;
    int req_cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    clkloss_ctrl #(.SYNC_STAGES(SYNC), .TIMEOUT(T), .PULSE_LEN(PL)) dut_i (
        .clk_ref(clk), .rst_ext_n(rst_n), .main_clk(mclk), .reg_wr(wr),
        .reg_wdata(wd), .reg_rdata(rd), .stop_exit(sexit), .int_rst_req(req),
        .preload_req(pre), .tmr_load_val(tval), .pre_load_val(pval)
    );

    // counts request cycles seen at rising edges
    always @(posedge clk) if (req) req_cycles <= req_cycles + 1;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic wreg(input logic [7:0] v);
        wr = 1'b1; wd = v;
        step(1);
        wr = 1'b0;
    endtask

    task automatic flip();
        mclk = ~mclk;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    function automatic logic [7:0] exp_write(input logic [7:0] w, input logic loss);
        return {4'b0, w[1] & loss, w[2:0]};
    endfunction

    function automatic logic [7:0] exp_fire(input logic [7:0] w);
        return w[2] ? 8'h0A : {4'b0, 1'b1, w[2:0]};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        int snap;
        void'($urandom(32'd5150));
        step(3);
        chk("R1 reset reg", rd, 8'h00);
        chk("R1 reset req", {7'b0, req}, 8'h00);
        chk("R1 reset preload", {7'b0, pre}, 8'h00);
        rst_n = 1'b1;

        // R2 layout and R7 ignored bit3
        wreg(8'h06);
        chk("R2 write", rd, 8'h06);
        wreg(8'hF7);
        chk("R2 R7 upper bits ignored", rd, 8'h07);

        // R4 spacing T never fires
        for (int i = 0; i < 5; i++) begin flip(); step(T); end
        chk("R4 gap T no loss", rd, 8'h07);

        // R4 latency, R5 pulse, R6, R9
        flip();
        snap = req_cycles;
        step(LAT - 1);
        chk("R4 before latency", {rd[3], req}, 8'h00);
        step(1);
        chk("R4 R5 flag and req", {rd[3], req}, 8'h03);
        wreg(8'h00);
        step(PL);
        chk("R6 R9 survivors", rd, 8'h0A);
        step(3 * T);
        chk("R5 R8 single pulse", 8'(req_cycles - snap), 8'(PL));
        chk("R8 sticky", rd, 8'h0A);

        // R7 clear, R5 no request when disabled
        wreg(8'h00);
        chk("R7 clear", rd, 8'h00);
        snap = req_cycles;
        wreg(8'h02);
        step(2 * T + 5);
        chk("R5 flag only", rd, 8'h0A);
        chk("R5 no req", 8'(req_cycles - snap), 8'h00);
        wreg(8'h03);
        chk("R7 arm keeps flag", rd, 8'h0B);

        // R3 disarmed
        wreg(8'h04);
        snap = req_cycles;
        step(3 * T);
        chk("R3 disarmed", rd, 8'h04);
        chk("R3 no req", 8'(req_cycles - snap), 8'h00);

        // R4 spacing T+1 fires
        wreg(8'h02);
        flip(); step(T + 1); flip(); step(T + 1);
        chk("R4 gap T+1 loss", rd, 8'h0A);

        // R1 clears set flag
        rst_n = 1'b0; step(1); rst_n = 1'b1;
        chk("R1 ext reset clears flag", rd, 8'h00);

        // R10 preload
        chk("R10 timer value", tval, 8'h01);
        chk("R10 prescaler value", pval, 8'hFF);
        sexit = 1'b1; step(1); sexit = 1'b0;
        chk("R10 preload", {7'b0, pre}, 8'h01);
        step(1);
        chk("R10 preload ends", {7'b0, pre}, 8'h00);
        wreg(8'h01);
        sexit = 1'b1; step(1); sexit = 1'b0;
        chk("R10 skip", {7'b0, pre}, 8'h00);
        step(1);
        chk("R10 skip later", {7'b0, pre}, 8'h00);

        // random: armed runs, then stop
        for (int it = 0; it < 30; it++) begin
            logic [7:0] w;
            int k, n;
            w = 8'($urandom);
            w[1] = 1'b1;
            k = 1 + int'($urandom % T);
            n = 3 + int'($urandom % 6);
            wreg(w);
            chk("R2 random write", rd, exp_write(w, 1'b0));
            for (int j = 0; j < n; j++) begin flip(); step(k); end
            chk("R4 random running", rd, exp_write(w, 1'b0));
            flip();
            snap = req_cycles;
            step(LAT - 1);
            chk("R4 random before", {7'b0, rd[3]}, 8'h00);
            step(1);
            chk("R5 random req", {rd[3], req}, {7'b1, w[2]});
            step(PL + 2);
            chk("R6 random after", rd, exp_fire(w));
            chk("R5 random length", 8'(req_cycles - snap), w[2] ? 8'(PL) : 8'h00);
            wreg(8'h00);
            chk("R7 random clear", rd, 8'h00);
        end
        summary();
    end
endmodule